// File: doc/BRIEF.md
# Synchronous External Read Wait Controller

This block runs single-beat synchronous reads on an external memory bus whose clock is the block's own clock. An internal requester hands over a read with a valid/ready handshake. The controller then opens an access by enabling the bus clock and asserting chip select and output enable. It counts a programmable number of wait states and returns the captured word, with an error flag, on a one-cycle response pulse.

The wait-state count has two meanings, chosen by a latency-mode bit. In fixed-latency mode the count alone places the data sampling edge. In ready-monitored mode the count places the first sample of the device's wait line. Data is then taken one cycle after ready is seen, because the device raises ready one bus clock ahead of valid data. A timeout ends an access whose device never becomes ready.

On the request side, `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester may hold `req_valid` high for as long as it likes. The response has no back-pressure. `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_data` and `rsp_err` in that cycle.

Top module: `srw_read_ctrl`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while no access or response is in progress. The wait count, latency mode and ready polarity are latched at acceptance.
- R2: Access cycles are numbered from 0, and cycle 0 is the cycle right after acceptance. Through every access cycle, `mem_cs_n` and `mem_oe_n` are 0 and `mem_clk_en` is 1. Outside access cycles they are 1, 1 and 0.
- R3: With latency mode 1 (fixed) and wait count W, the access lasts W+1 cycles. `mem_rdata` is captured at the rising edge that ends cycle W.
- R4: With latency mode 0 (ready-monitored), the wait line is first sampled at the edge that ends cycle W. Its values before that edge have no effect.
- R5: In ready-monitored mode, if ready is seen at the edge ending cycle j, data is captured at the edge ending cycle j+1. With W=1 and immediate ready, the access takes three cycles.
- R6: While the wait line is sampled not-ready, the controller keeps the access open and samples again at every edge.
- R7: After 255 (`TIMEOUT`) consecutive not-ready samples, the access ends. The response then carries `rsp_err`=1 and `rsp_data`=0. On success `rsp_err` is 0.
- R8: With polarity bit 1, a high wait line means ready. With polarity bit 0, a low wait line means ready.
- R9: In the cycle after the last access cycle, chip select is deasserted and `rsp_valid` is 1 for exactly one cycle. `req_ready` returns to 1 in the following cycle.
- R10: Changes to `cfg_wait_cnt`, `cfg_fixed_lat` and `cfg_rdy_high` during an access have no effect on that access.
- R11: During and right after reset, `req_ready`=1, `mem_cs_n`=1, `mem_oe_n`=1, `mem_clk_en`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| cfg_wait_cnt | input | WCNT_W | Wait-state count, latched on acceptance |
| cfg_fixed_lat | input | 1 | 1: fixed latency, 0: ready-monitored |
| cfg_rdy_high | input | 1 | 1: wait line high means ready, 0: low means ready |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Captured read word (0 on timeout) |
| rsp_err | output | 1 | Timeout flag, valid with rsp_valid |
| mem_clk_en | output | 1 | Bus clock enable toward the device |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wait | input | 1 | Device wait/ready line |
| mem_rdata | input | DATA_W | Device read data |

## Verification
The assertions assume that `mem_wait` and `mem_rdata` are stable around each rising edge. They also assume the wait count is within its field width, so the latch counter never has to wrap. The stimulus drives every input only on falling edges. It gives the wait line a value per access cycle: ready before cycle W, where it must be ignored, then a chosen number of not-ready cycles, then ready. Configuration is scrambled on the falling edge after acceptance, so that a wrongly unlatched setting becomes visible.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_POLL,
    ST_CAPT,
    ST_RESP
  } srw_state_e;
endpackage

// File: rtl/srw_span_cnt.sv
module srw_span_cnt #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (inc) value <= value + 1'b1;
  end

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (value != {WIDTH{1'b1}}));
endmodule

// File: rtl/srw_rdy_decode.sv
module srw_rdy_decode (
  input  logic wait_in,
  input  logic rdy_high,
  output logic rdy
);
  always_comb rdy = rdy_high ? wait_in : ~wait_in;
endmodule

// File: rtl/srw_read_ctrl.sv
module srw_read_ctrl #(
  parameter int DATA_W  = 32,
  parameter int WCNT_W  = 6,
  parameter int TIMEOUT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WCNT_W-1:0] cfg_wait_cnt,
  input  logic              cfg_fixed_lat,
  input  logic              cfg_rdy_high,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              mem_clk_en,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  input  logic              mem_wait,
  input  logic [DATA_W-1:0] mem_rdata
);
  import srw_pkg::*;

  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

  srw_state_e        state, state_nx;
  logic [WCNT_W-1:0] lat_w;
  logic              lat_fix, lat_pol;
  logic              cs_q, err_q;
  logic [DATA_W-1:0] data_q;
  logic [WCNT_W-1:0] ph_val;
  logic [TO_W-1:0]   to_val;
  logic              accept, rdy, abort, lat_done;

  assign accept   = req_valid && (state == ST_IDLE);
  assign lat_done = (state == ST_LAT) && (ph_val == lat_w - 1'b1);
  assign abort    = (state == ST_POLL) && !rdy && (to_val == TO_LAST);

  srw_rdy_decode u_rdy (
    .wait_in  (mem_wait),
    .rdy_high (lat_pol),
    .rdy      (rdy)
  );

  srw_span_cnt #(.WIDTH(WCNT_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (state == ST_LAT),
    .value (ph_val)
  );

  srw_span_cnt #(.WIDTH(TO_W)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   ((state == ST_POLL) && !rdy && !abort),
    .value (to_val)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        if (cfg_wait_cnt == '0) state_nx = cfg_fixed_lat ? ST_CAPT : ST_POLL;
        else                    state_nx = ST_LAT;
      end
      ST_LAT:  if (lat_done) state_nx = lat_fix ? ST_CAPT : ST_POLL;
      ST_POLL: if (rdy) state_nx = ST_CAPT;
               else if (abort) state_nx = ST_RESP;
      ST_CAPT: state_nx = ST_RESP;
      ST_RESP: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lat_w   <= '0;
      lat_fix <= 1'b0;
      lat_pol <= 1'b0;
      cs_q    <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        lat_w   <= cfg_wait_cnt;
        lat_fix <= cfg_fixed_lat;
        lat_pol <= cfg_rdy_high;
        cs_q    <= 1'b1;
      end
      if (state == ST_CAPT) begin
        data_q <= mem_rdata;
        err_q  <= 1'b0;
        cs_q   <= 1'b0;
      end else if (abort) begin
        data_q <= '0;
        err_q  <= 1'b1;
        cs_q   <= 1'b0;
      end else if (state == ST_RESP) begin
        err_q <= 1'b0;
      end
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_data   = data_q;
  assign rsp_err    = err_q;
  assign mem_cs_n   = ~cs_q;
  assign mem_oe_n   = ~cs_q;
  assign mem_clk_en = cs_q;

  // R2
  idle_cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && !mem_clk_en));

  // R2
  accept_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!mem_cs_n && !mem_oe_n && mem_clk_en));

  // R6
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_POLL) && !rdy && !abort) |=> (!mem_cs_n && (state == ST_POLL)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9
  rsp_cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_cs_n);

  // R7
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R10
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(accept)) |-> ($stable(lat_w) && $stable(lat_fix) && $stable(lat_pol)));
endmodule

// File: tb/srw_read_ctrl_tb.sv
module srw_read_ctrl_tb;
  localparam int DW = 32;
  localparam int WW = 6;
  localparam int TO = 255;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [WW-1:0] cfg_wait_cnt = '0;
  logic          cfg_fixed_lat = 1'b0;
  logic          cfg_rdy_high = 1'b0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data;
  logic          mem_clk_en, mem_cs_n, mem_oe_n;
  logic          mem_wait = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  srw_read_ctrl #(.DATA_W(DW), .WCNT_W(WW), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_wait_cnt(cfg_wait_cnt), .cfg_fixed_lat(cfg_fixed_lat), .cfg_rdy_high(cfg_rdy_high),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_clk_en(mem_clk_en), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_wait(mem_wait), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 access, 2 response
  int            m_ph = 0, m_cyc = 0, m_w = 0, m_nr = 0;
  bit            m_fix = 0, m_pol = 0, m_seen = 0, m_err = 0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_err = 0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
          m_w = int'(cfg_wait_cnt); m_fix = cfg_fixed_lat; m_pol = cfg_rdy_high;
          m_cyc = 0; m_seen = 0; m_nr = 0; m_ph = 1;
        end
        1: begin
          if (m_fix) begin
            if (m_cyc == m_w) begin m_data = mem_rdata; m_err = 0; m_ph = 2; end
          end else if (m_seen) begin
            m_data = mem_rdata; m_err = 0; m_ph = 2;
          end else if (m_cyc >= m_w) begin
            if ((m_pol && mem_wait) || (!m_pol && !mem_wait)) m_seen = 1;
            else begin
              m_nr++;
              if (m_nr == TO) begin m_err = 1; m_data = '0; m_ph = 2; end
            end
          end
          m_cyc++;
        end
        default: begin m_ph = 0; m_err = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (m_ph == 0), "R1", "req_ready vs model", req_ready, m_ph == 0);
      chk(mem_cs_n == (m_ph != 1) && mem_oe_n == (m_ph != 1) && mem_clk_en == (m_ph == 1),
          "R2", "cs/oe/clk_en vs model", {mem_cs_n, mem_oe_n, mem_clk_en},
          {m_ph != 1, m_ph != 1, m_ph == 1});
      chk(rsp_valid == (m_ph == 2), "R9", "rsp_valid vs model", rsp_valid, m_ph == 2);
      chk(rsp_err == ((m_ph == 2) && m_err), "R7", "rsp_err vs model", rsp_err,
          (m_ph == 2) && m_err);
      if (m_ph == 2)
        chk(rsp_data == m_data, "R3/R5", "rsp_data vs model", rsp_data, m_data);
    end
  end

  // One read; cycle c wait line: ready for c<w (ignored), not-ready for nr cycles, then ready
  task automatic do_read(input int w, input bit fx, input bit pol, input int nr,
                         input logic [DW-1:0] d, input string req);
    int c;
    int exp_c;
    logic [DW-1:0] exp_d;
    bit got;
    @(negedge clk);
    req_valid = 1'b1; cfg_wait_cnt = WW'(w); cfg_fixed_lat = fx; cfg_rdy_high = pol;
    mem_wait = pol; mem_rdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble configuration once the access is under way
    cfg_wait_cnt = ~WW'(w); cfg_fixed_lat = ~fx; cfg_rdy_high = ~pol;
    if (fx)           begin exp_c = w + 1;      exp_d = d ^ DW'(w);        end
    else if (nr >= TO) begin exp_c = w + TO;    exp_d = '0;                end
    else              begin exp_c = w + nr + 2; exp_d = d ^ DW'(w + nr + 1); end
    got = 1'b0;
    for (c = 0; c < 600 && !got; c++) begin
      if (c > 0) @(negedge clk);
      mem_rdata = d ^ DW'(c);
      if (c < w || c >= w + nr) mem_wait = pol;
      else mem_wait = ~pol;
      if (rsp_valid) got = 1'b1;
      else if (c < exp_c)
        chk(!mem_cs_n && !req_ready, "R2", "access held open", mem_cs_n, 0);
    end
    chk(got && (c - 1) == exp_c, req, "response cycle", c - 1, exp_c);
    chk(rsp_data == exp_d, req, "response data", rsp_data, exp_d);
    chk(rsp_err == (!fx && nr >= TO), "R7", "error flag", rsp_err, !fx && nr >= TO);
    chk(mem_cs_n, "R9", "cs released at response", mem_cs_n, 1);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "single pulse then idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n && mem_oe_n && !mem_clk_en && !rsp_valid, "R11",
        "in reset", {req_ready, mem_cs_n, mem_oe_n, mem_clk_en, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !rsp_valid, "R11", "after reset",
        {req_ready, mem_cs_n, rsp_valid}, 3'b110);
    do_read(1, 1'b1, 1'b1, 0, 32'hA5A5_0000, "R3");
    do_read(0, 1'b1, 1'b0, 0, 32'h1234_5600, "R3");
    do_read(5, 1'b1, 1'b1, 3, 32'hCAFE_0000, "R3");
    do_read(63, 1'b1, 1'b0, 0, 32'h0F0F_0000, "R3");
    do_read(1, 1'b0, 1'b1, 0, 32'hBEEF_0000, "R5");
    do_read(0, 1'b0, 1'b1, 0, 32'h7777_0000, "R5");
    do_read(3, 1'b0, 1'b0, 4, 32'h5555_0000, "R4 R6 R8");
    do_read(2, 1'b0, 1'b1, 2, 32'h9999_0000, "R4 R6 R8");
    do_read(4, 1'b0, 1'b0, 254, 32'h4242_0000, "R7");
    do_read(2, 1'b0, 1'b1, 400, 32'h1111_0000, "R7");
    do_read(0, 1'b0, 1'b0, 300, 32'h2222_0000, "R7");
    do_read(7, 1'b0, 1'b0, 1, 32'h3333_0000, "R10");
    // R1: request held while busy is taken only when idle
    @(negedge clk);
    req_valid = 1'b1; cfg_wait_cnt = 6'd2; cfg_fixed_lat = 1'b1; cfg_rdy_high = 1'b1;
    repeat (12) @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(req_ready, "R1", "idle after held requests", req_ready, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule